// File: doc/BRIEF.md
# Selectable Clock Divider Output Banks

This block runs from a single fast reference clock and derives two divided clocks from it: a primary clock at one half of the reference rate and a slow clock at one quarter of the reference rate. Both have an exact 50% duty cycle, whatever the duty cycle of the reference. Twelve outputs are arranged as four banks of three. A 2-bit select input sets how many of the low-numbered banks carry the slow clock. The remaining banks carry the primary clock. The last bank always carries the primary clock, so it can be wired back as a fixed-rate feedback signal.

Three further controls act on the outputs. An active-high force input drives every output low. A falling edge on the clear input restarts the slow divider, which pulls the slow-rate banks low. A static test input bypasses the dividers and puts the raw reference clock on the outputs. The select, force and clear inputs are resampled through synchronizer flops before use. Every divided output comes from a flop clocked by the reference.

Top module: `clock_bank_divider`

## Requirements
- R1: The last bank toggles on every rising edge of `clk` while the outputs are not forced. Each slow-rate bank changes level exactly on those edges where the last bank goes from 0 to 1, so both divided clocks are 50% and have coincident rising edges.
- R2: Bank k (k = 1..4) drives bits `bankOut[3k-1:3k-3]`, and its three bits always carry the same value.
- R3: The select value s (0 to 3) puts banks 1..s on the slow clock and the other banks on the primary clock: 00 gives none, 01 gives bank 1, 10 gives banks 1 and 2, 11 gives banks 1 to 3.
- R4: Bank 4 carries the primary clock for every select value.
- R5: While `forceLow` is 1, all outputs read 0 from the third rising edge after it rises. After it returns to 0, the outputs resume toggling.
- R6: A 1-to-0 transition on `clearN` makes every slow-rate bank read 0 on the fourth rising edge after the transition. Primary-rate banks keep toggling undisturbed through the clear.
- R7: While `testBypass` is 1 and the outputs are not forced, every output equals `clk`. With `forceLow` also set, every output is 0.
- R8: While `rst` is 1 at a rising edge, all outputs read 0. With select 00, all outputs read 1 after the second rising edge following reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bankSel | input | 2 | Count of low banks placed on the slow clock |
| forceLow | input | 1 | Active-high force of all outputs to 0 |
| clearN | input | 1 | Falling edge restarts the slow divider |
| testBypass | input | 1 | Static test strap; 1 routes `clk` to outputs |
| bankOut | output | 12 | Four banks of three outputs, bank 1 in the low bits |

## Verification
The bench builds the block with its default parameters: four banks of three outputs and two synchronizer stages. With these values every select code is reachable, including code 11, which leaves only the last bank at the primary rate. The bench also sees the full synchronizer latency on force and clear as fixed edge counts. Each select code is checked by following the slow banks against rising edges of the last bank. Clear is applied at two divider phases so that the fixed fourth-edge low point is tested whether it cuts a high phase short or not.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

  // Single-cycle strobes handed from control to the datapath.
  typedef struct packed {
    logic clearHalf;   // restart the quarter-rate divider
    logic forceLow;    // hold all output flops at zero
  } ctlStrobe_t;

endpackage

// File: rtl/cb_sync.sv
module cb_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= RESET_VAL;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/cb_control.sv
module cb_control
  import clkbank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     bankSel,
  input  logic                 forceLowIn,
  input  logic                 clearNIn,
  output ctlStrobe_t           strobe,
  output logic [NUM_BANKS-1:0] halfMask
);

  logic [SEL_W-1:0] selSync;
  logic [1:0]       ctlSync;   // {forceLow, clearN}
  logic             clearPrevQ;

  cb_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) uSelSync (
    .clk(clk), .rst(rst), .din(bankSel), .dout(selSync)
  );

  cb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b01)) uCtlSync (
    .clk(clk), .rst(rst), .din({forceLowIn, clearNIn}), .dout(ctlSync)
  );

  // Edge history of the synchronized clear input.
  always_ff @(posedge clk) begin
    if (rst) clearPrevQ <= 1'b1;
    else     clearPrevQ <= ctlSync[0];
  end

  assign strobe.forceLow  = ctlSync[1];
  assign strobe.clearHalf = clearPrevQ & ~ctlSync[0];

  // Select value s moves banks 0..s-1 to the slow clock; the last bank never moves.
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : gMask
      if (b == NUM_BANKS - 1) begin : gFixed
        assign halfMask[b] = 1'b0;
      end else begin : gSel
        assign halfMask[b] = (int'(selSync) > b);
      end
    end
  endgenerate

  // R3: slow banks always form a contiguous run from bank 1
  a_r3_mask_thermo: assert property (@(posedge clk) disable iff (rst)
    (halfMask & (halfMask + 1'b1)) == '0);

  // R6: a falling clear yields exactly one strobe
  a_r6_clear_single: assert property (@(posedge clk) disable iff (rst)
    strobe.clearHalf |=> !strobe.clearHalf);

endmodule

// File: rtl/cb_datapath.sv
module cb_datapath
  import clkbank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OUTS_PER_BANK = 3,
  localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlStrobe_t           strobe,
  input  logic [NUM_BANKS-1:0] halfMask,
  output logic [NUM_OUTS-1:0]  outQ
);

  logic div2Q;
  logic div4Q;
  logic [NUM_OUTS-1:0] outNext;

  // div4 toggles while div2 is low, so both rise on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      div2Q <= 1'b0;
      div4Q <= 1'b0;
    end else begin
      div2Q <= ~div2Q;
      if (strobe.clearHalf) div4Q <= 1'b0;
      else if (!div2Q)      div4Q <= ~div4Q;
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
      for (genvar o = 0; o < OUTS_PER_BANK; o++) begin : gOut
        assign outNext[b*OUTS_PER_BANK + o] = halfMask[b] ? div4Q : div2Q;
      end
      // R2: all outputs of one bank agree
      a_r2_bank_uniform: assert property (@(posedge clk) disable iff (rst)
        (outQ[b*OUTS_PER_BANK +: OUTS_PER_BANK] == '0) ||
        (outQ[b*OUTS_PER_BANK +: OUTS_PER_BANK] == '1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                  outQ <= '0;
    else if (strobe.forceLow) outQ <= '0;
    else                      outQ <= outNext;
  end

  // R1: the slow clock rises only together with the primary clock
  a_r1_div4_in_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(div4Q) |-> $rose(div2Q));

  // R5: force strobe empties every output flop on the next edge
  a_r5_force_low: assert property (@(posedge clk) disable iff (rst)
    strobe.forceLow |=> (outQ == '0));

  // R6: clear strobe leaves the slow divider low
  a_r6_clear_drops_half: assert property (@(posedge clk) disable iff (rst)
    strobe.clearHalf |=> !div4Q);

endmodule

// File: rtl/clock_bank_divider.sv
module clock_bank_divider
  import clkbank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OUTS_PER_BANK = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(NUM_BANKS),
  localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    bankSel,
  input  logic                forceLow,
  input  logic                clearN,
  input  logic                testBypass,
  output logic [NUM_OUTS-1:0] bankOut
);

  ctlStrobe_t           strobe;
  logic [NUM_BANKS-1:0] halfMask;
  logic [NUM_OUTS-1:0]  outQ;

  cb_control #(.NUM_BANKS(NUM_BANKS), .SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk(clk), .rst(rst), .bankSel(bankSel), .forceLowIn(forceLow),
    .clearNIn(clearN), .strobe(strobe), .halfMask(halfMask)
  );

  cb_datapath #(.NUM_BANKS(NUM_BANKS), .OUTS_PER_BANK(OUTS_PER_BANK)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .halfMask(halfMask), .outQ(outQ)
  );

  // Test strap: raw reference on every output, still subject to the force.
  assign bankOut = testBypass ? ({NUM_OUTS{clk}} & {NUM_OUTS{~strobe.forceLow}})
                              : outQ;

endmodule

// File: tb/sim_clock_bank_divider.sv
module sim_clock_bank_divider;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bankSel = 2'b00;
  logic        forceLow = 1'b0;
  logic        clearN = 1'b1;
  logic        testBypass = 1'b0;
  logic [11:0] bankOut;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  clock_bank_divider u0 (
    .clk(clk), .rst(rst), .bankSel(bankSel), .forceLow(forceLow),
    .clearN(clearN), .testBypass(testBypass), .bankOut(bankOut)
  );

  task automatic check(input bit ok, input string req, input logic [11:0] act,
                       input logic [11:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %03h expected %03h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(bankOut == 12'h000, "R8 reset low", bankOut, 12'h000);
    rst = 1'b0;
    @(negedge clk);
    check(bankOut == 12'h000, "R8 first edge", bankOut, 12'h000);
    @(negedge clk);
    check(bankOut == 12'hfff, "R8 first rise", bankOut, 12'hfff);
  endtask

  task automatic run_select(input logic [1:0] sel);
    logic [11:0] prevOut;
    bankSel = sel;
    repeat (6) @(negedge clk);
    prevOut = bankOut;
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        logic [2:0] g;
        g = bankOut[b*3 +: 3];
        check(g == 3'b000 || g == 3'b111, "R2 bank uniform", bankOut, {4{g[0], g[0], g[0]}});
      end
      check(bankOut[9] != prevOut[9], "R1 R4 last bank toggles", bankOut, prevOut ^ 12'h200);
      for (int b = 0; b < 3; b++) begin
        if (b < int'(sel)) begin
          bit rose, changed;
          rose = bankOut[9] && !prevOut[9];
          changed = bankOut[b*3] != prevOut[b*3];
          check(changed == rose, "R3 slow bank edge", bankOut, prevOut);
        end else begin
          check(bankOut[b*3] == bankOut[9], "R3 primary bank", bankOut, {12{bankOut[9]}});
        end
      end
      prevOut = bankOut;
    end
  endtask

  task automatic run_force();
    logic [11:0] prevOut;
    forceLow = 1'b1;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 6; s++) begin
      check(bankOut == 12'h000, "R5 forced low", bankOut, 12'h000);
      @(negedge clk);
    end
    forceLow = 1'b0;
    repeat (5) @(negedge clk);
    prevOut = bankOut;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      check(bankOut[9] != prevOut[9], "R5 resumes", bankOut, prevOut ^ 12'h200);
      prevOut = bankOut;
    end
  endtask

  task automatic run_clear(input logic [1:0] sel, input int skew);
    logic [11:0] prevOut;
    bankSel = sel;
    repeat (6 + skew) @(negedge clk);
    prevOut = bankOut;
    clearN = 1'b0;
    for (int s = 1; s <= 4; s++) begin
      @(negedge clk);
      check(bankOut[9] != prevOut[9], "R6 primary untouched", bankOut, prevOut ^ 12'h200);
      if (sel == 2'b00)
        check(bankOut == {12{bankOut[9]}}, "R6 no slow banks", bankOut, {12{bankOut[9]}});
      prevOut = bankOut;
    end
    if (sel != 2'b00)
      for (int b = 0; b < int'(sel); b++)
        check(bankOut[b*3 +: 3] == 3'b000, "R6 slow bank cleared", bankOut,
              bankOut & ~(12'h007 << (b*3)));
    clearN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic run_bypass();
    testBypass = 1'b1;
    for (int s = 0; s < 3; s++) begin
      @(posedge clk); #5;
      check(bankOut == 12'hfff, "R7 bypass high", bankOut, 12'hfff);
      @(negedge clk); #5;
      check(bankOut == 12'h000, "R7 bypass low", bankOut, 12'h000);
    end
    @(negedge clk);
    forceLow = 1'b1;
    repeat (4) @(negedge clk);
    @(posedge clk); #5;
    check(bankOut == 12'h000, "R7 bypass forced", bankOut, 12'h000);
    @(negedge clk);
    forceLow = 1'b0;
    testBypass = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    run_reset();
    run_select(2'b00);
    run_select(2'b01);
    run_select(2'b10);
    run_select(2'b11);
    run_force();
    run_clear(2'b11, 0);
    run_clear(2'b10, 1);
    run_clear(2'b00, 0);
    run_bypass();
    run_select(2'b01);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule